// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block expands one read or write command into the stream of column addresses a synchronous DRAM burst needs, one beat per clock. It serves a controller for a four-bank part with a 16-bit data path. A command names a bank and a start column. The block then issues beats in either a linear-wrap order or an XOR order, inside an aligned block whose size is the burst length. In full-page mode it walks the whole 256-column page without stopping.

A separate mode word sets the burst length, the order and the read latency. The block refuses any mode word that cannot be legal, and raises a flag when it does. For every read beat it issues, it raises a read-valid strobe 2 or 3 cycles later. A terminate command stops the burst at once. A fresh read or write may take the place of a running burst on any cycle. Each beat carries a two-bit byte mask, one bit per byte lane.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset `col_valid`, `rd_valid`, `col_mask` and `mode_err` are 0. The mode in force is burst length 1, linear order, read latency 2.
- R2: A command on `cmd_op` is taken at the rising edge where it is sampled. The codes are 01 read, 10 write, 11 terminate and 00 idle. After a read or write, `col_valid` is 1 in the next cycle with `col_addr` equal to the start column and with the command's bank and direction. Write beats have no added latency.
- R3: Linear order for burst lengths 2, 4 and 8: beat k has the upper column bits of the start column. Its low log2(length) bits are (start + k) modulo the length.
- R4: XOR order for burst lengths 2, 4 and 8: beat k is the start column XOR k, with k confined to the low log2(length) bits. After the last beat `col_valid` returns to 0.
- R5: Full page is linear only. Each beat is one more than the previous one, wrapping from column 255 to 0. The burst runs until a terminate or a new command arrives.
- R6: The mode word `mode_word` is taken when `mode_load` is 1. Bits [2:0] give the length: 0=1, 1=2, 2=4, 3=8, 7=full page. Bit 3 selects XOR order. Bits [5:4] give the read latency and must be 2 or 3. A word with length code 4 to 6, with full page together with XOR order, or with a latency other than 2 or 3 leaves the mode unchanged and sets `mode_err`. The next legal word clears `mode_err`.
- R7: `rd_valid` is 1 exactly L cycles after each cycle in which a read beat shows on `col_valid`, where L is the read latency in force.
- R8: After a terminate, `col_valid` is 0 from the next cycle on. Read beats that were already issued still produce their `rd_valid` strobes.
- R9: A read or write that arrives during a burst replaces it in the very next cycle. Unissued beats of the old burst are dropped, while old read beats already issued keep their `rd_valid` strobes.
- R10: `col_mask` carries the `beat_mask` value sampled at the same edge that issues the beat. Bit 1 is the upper byte and bit 0 the lower byte. In cycles with no beat, `col_mask` is 0.
- R11: A terminate or an idle code while no burst runs leaves `col_valid` and `rd_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_load | input | 1 | Take `mode_word` at this edge |
| mode_word | input | 6 | Length code [2:0], XOR order [3], read latency [5:4] |
| cmd_op | input | 2 | 00 idle, 01 read, 10 write, 11 terminate |
| cmd_bank | input | 2 | Bank for a read or write |
| cmd_col | input | 8 | Start column for a read or write |
| beat_mask | input | 2 | Byte-lane mask for the beat issued at this edge |
| col_valid | output | 1 | A beat is issued this cycle |
| col_addr | output | 8 | Column of the current beat |
| col_bank | output | 2 | Bank of the current beat |
| col_write | output | 1 | Current beat is a write |
| col_mask | output | 2 | Byte-lane mask of the current beat |
| rd_valid | output | 1 | Read data of an earlier read beat is valid |
| mode_err | output | 1 | Last mode word was rejected |

## Verification
The latency assertions assume the mode word does not change while read beats are still in the delay line. The full-page assertion assumes the burst length and order stay fixed while a burst runs. To keep within these limits, the stimulus loads a new mode only after at least four idle cycles, and never in the same cycle as a command. Interrupts and terminates are sent at chosen beats of a running burst, because the bench can predict those cycles exactly.

// File: rtl/sdram_bseq_pkg.sv
package sdram_bseq_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_TERM  = 2'b11
  } op_e;

  localparam int unsigned MODE_W    = 6;
  localparam int unsigned LEN_LOG_W = 2;
  localparam logic [2:0]  LEN_FULL  = 3'd7;

  // Legal: length code 0..3, or full page in linear order; latency 2 or 3.
  function automatic logic mode_legal(input logic [MODE_W-1:0] w);
    logic [2:0] len;
    logic       xo;
    logic [1:0] lat;
    len = w[2:0];
    xo  = w[3];
    lat = w[5:4];
    mode_legal = ((len <= 3'd3) || ((len == LEN_FULL) && !xo)) &&
                 ((lat == 2'd2) || (lat == 2'd3));
  endfunction

endpackage

// File: rtl/sdram_bseq_mode.sv
module sdram_bseq_mode
  import sdram_bseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [MODE_W-1:0]    word,
  output logic [LEN_LOG_W-1:0] len_log,
  output logic                 full,
  output logic                 xor_ord,
  output logic                 lat_hi,
  output logic                 err
);

  logic ok;
  assign ok = mode_legal(word);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_log <= '0;
      full    <= 1'b0;
      xor_ord <= 1'b0;
      lat_hi  <= 1'b0;
      err     <= 1'b0;
    end else if (load) begin
      if (ok) begin
        full    <= (word[2:0] == LEN_FULL);
        len_log <= (word[2:0] == LEN_FULL) ? '0 : word[LEN_LOG_W-1:0];
        xor_ord <= word[3];
        lat_hi  <= word[4];
        err     <= 1'b0;
      end else begin
        err     <= 1'b1;
      end
    end
  end

  AST_MODE_REJECT: assert property (@(posedge clk) disable iff (rst)
    (load && !mode_legal(word)) |=> (err && $stable({len_log, full, xor_ord, lat_hi}))); // R6
  AST_MODE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (load && mode_legal(word)) |=> !err); // R6
  AST_FULL_LINEAR: assert property (@(posedge clk) disable iff (rst)
    full |-> !xor_ord); // R5

endmodule

// File: rtl/sdram_bseq_colgen.sv
module sdram_bseq_colgen
  import sdram_bseq_pkg::*;
#(
  parameter int unsigned COL_W  = 8,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned MASK_W = 2,
  parameter bit          XOR_EN = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 term,
  input  logic                 cmd_wr,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic [COL_W-1:0]     cmd_col,
  input  logic [MASK_W-1:0]    beat_mask,
  input  logic [LEN_LOG_W-1:0] len_log,
  input  logic                 full,
  input  logic                 xor_ord,
  output logic                 col_valid,
  output logic [COL_W-1:0]     col_addr,
  output logic [BANK_W-1:0]    col_bank,
  output logic                 col_wr,
  output logic [MASK_W-1:0]    col_mask
);

  logic              active_q, full_q, xor_q, wr_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  base_q, cnt_q, span_q;
  logic [COL_W-1:0]  span_new, lin_addr, nxt_addr;

  always_comb begin
    span_new = full ? {COL_W{1'b1}} : ~({COL_W{1'b1}} << len_log);
    lin_addr = (base_q & ~span_q) | ((base_q + cnt_q) & span_q);
  end

  generate
    if (XOR_EN) begin : g_xor
      logic [COL_W-1:0] xor_addr;
      assign xor_addr = base_q ^ (cnt_q & span_q);
      assign nxt_addr = xor_q ? xor_addr : lin_addr;
    end else begin : g_lin
      assign nxt_addr = lin_addr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      full_q    <= 1'b0;
      xor_q     <= 1'b0;
      wr_q      <= 1'b0;
      bank_q    <= '0;
      base_q    <= '0;
      cnt_q     <= '0;
      span_q    <= '0;
      col_valid <= 1'b0;
      col_addr  <= '0;
      col_bank  <= '0;
      col_wr    <= 1'b0;
      col_mask  <= '0;
    end else if (start) begin
      col_valid <= 1'b1;
      col_addr  <= cmd_col;
      col_bank  <= cmd_bank;
      col_wr    <= cmd_wr;
      col_mask  <= beat_mask;
      base_q    <= cmd_col;
      bank_q    <= cmd_bank;
      wr_q      <= cmd_wr;
      cnt_q     <= COL_W'(1);
      span_q    <= span_new;
      full_q    <= full;
      xor_q     <= xor_ord && !full;
      active_q  <= full || (len_log != '0);
    end else if (term) begin
      active_q  <= 1'b0;
      col_valid <= 1'b0;
      col_mask  <= '0;
    end else if (active_q) begin
      col_valid <= 1'b1;
      col_addr  <= nxt_addr;
      col_bank  <= bank_q;
      col_wr    <= wr_q;
      col_mask  <= beat_mask;
      cnt_q     <= cnt_q + COL_W'(1);
      if (!full_q && (cnt_q == span_q)) active_q <= 1'b0;
    end else begin
      col_valid <= 1'b0;
      col_mask  <= '0;
    end
  end

  AST_START_BEAT0: assert property (@(posedge clk) disable iff (rst)
    start |=> (col_valid && (col_addr == $past(cmd_col)) && (col_wr == $past(cmd_wr)))); // R2
  AST_TERM_HALT: assert property (@(posedge clk) disable iff (rst)
    term |=> !col_valid); // R8
  AST_FULL_STEP: assert property (@(posedge clk) disable iff (rst)
    (active_q && full_q && !start && !term) |=>
      (col_valid && (col_addr == COL_W'($past(col_addr) + 1'b1)))); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!active_q && !start) |=> (!col_valid && (col_mask == '0))); // R11

endmodule

// File: rtl/sdram_bseq_rdpipe.sv
module sdram_bseq_rdpipe #(
  parameter int unsigned RL_LO = 2,
  parameter int unsigned RL_HI = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic in_bit,
  input  logic lat_hi,
  output logic out_bit
);

  localparam int unsigned DEPTH = RL_HI;

  logic [DEPTH-1:0] stg_q;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stg
      always_ff @(posedge clk) begin
        if (rst) stg_q[i] <= 1'b0;
        else     stg_q[i] <= (i == 0) ? in_bit : stg_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign out_bit = lat_hi ? stg_q[RL_HI-1] : stg_q[RL_LO-1];

  generate
    if (RL_LO == 2 && RL_HI == 3) begin : g_chk
      AST_RD_LAT_LO: assert property (@(posedge clk) disable iff (rst)
        (in_bit && !lat_hi) |=> ##1 out_bit); // R7
      AST_RD_LAT_HI: assert property (@(posedge clk) disable iff (rst)
        (in_bit && lat_hi) |=> ##2 out_bit); // R7
    end
  endgenerate

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_bseq_pkg::*;
#(
  parameter int unsigned COL_W  = 8,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned MASK_W = 2,
  parameter int unsigned RL_LO  = 2,
  parameter int unsigned RL_HI  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_load,
  input  logic [5:0]        mode_word,
  input  logic [1:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [MASK_W-1:0] beat_mask,
  output logic              col_valid,
  output logic [COL_W-1:0]  col_addr,
  output logic [BANK_W-1:0] col_bank,
  output logic              col_write,
  output logic [MASK_W-1:0] col_mask,
  output logic              rd_valid,
  output logic              mode_err
);

  logic [LEN_LOG_W-1:0] len_log;
  logic                 full, xor_ord, lat_hi;
  logic                 start, term, is_wr;

  assign start = (cmd_op == OP_READ) || (cmd_op == OP_WRITE);
  assign term  = (cmd_op == OP_TERM);
  assign is_wr = (cmd_op == OP_WRITE);

  sdram_bseq_mode u_mode (
    .clk     (clk),
    .rst     (rst),
    .load    (mode_load),
    .word    (mode_word),
    .len_log (len_log),
    .full    (full),
    .xor_ord (xor_ord),
    .lat_hi  (lat_hi),
    .err     (mode_err)
  );

  sdram_bseq_colgen #(
    .COL_W  (COL_W),
    .BANK_W (BANK_W),
    .MASK_W (MASK_W),
    .XOR_EN (1'b1)
  ) u_colgen (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .term      (term),
    .cmd_wr    (is_wr),
    .cmd_bank  (cmd_bank),
    .cmd_col   (cmd_col),
    .beat_mask (beat_mask),
    .len_log   (len_log),
    .full      (full),
    .xor_ord   (xor_ord),
    .col_valid (col_valid),
    .col_addr  (col_addr),
    .col_bank  (col_bank),
    .col_wr    (col_write),
    .col_mask  (col_mask)
  );

  sdram_bseq_rdpipe #(
    .RL_LO (RL_LO),
    .RL_HI (RL_HI)
  ) u_rdpipe (
    .clk     (clk),
    .rst     (rst),
    .in_bit  (col_valid && !col_write),
    .lat_hi  (lat_hi),
    .out_bit (rd_valid)
  );

endmodule

// File: tb/sdram_burst_seq_tb.sv
module sdram_burst_seq_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       mode_load;
  logic [5:0] mode_word;
  logic [1:0] cmd_op;
  logic [1:0] cmd_bank;
  logic [7:0] cmd_col;
  logic [1:0] beat_mask;
  logic       col_valid, col_write, rd_valid, mode_err;
  logic [7:0] col_addr;
  logic [1:0] col_bank, col_mask;

  always #4 clk = ~clk;

  sdram_burst_seq u_dut (
    .clk(clk), .rst(rst), .mode_load(mode_load), .mode_word(mode_word),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_col(cmd_col), .beat_mask(beat_mask),
    .col_valid(col_valid), .col_addr(col_addr), .col_bank(col_bank),
    .col_write(col_write), .col_mask(col_mask), .rd_valid(rd_valid), .mode_err(mode_err)
  );

  typedef struct packed {
    logic [5:0]  mode;
    logic [7:0]  col;
    logic        wr;
    logic [3:0]  n;
    logic [63:0] exp;
  } vec_t;

  // beat 0 in exp[7:0]
  localparam vec_t TBL [7] = '{
    '{6'h21, 8'h13, 1'b0, 4'd2, 64'h0000_0000_0000_1213},  // R3 len 2 linear
    '{6'h22, 8'h26, 1'b0, 4'd4, 64'h0000_0000_2524_2726},  // R3 len 4 linear
    '{6'h23, 8'h5D, 1'b0, 4'd8, 64'h5C5B_5A59_585F_5E5D},  // R3 len 8 linear
    '{6'h2A, 8'h27, 1'b0, 4'd4, 64'h0000_0000_2425_2627},  // R4 len 4 xor
    '{6'h2B, 8'h5D, 1'b0, 4'd8, 64'h5A5B_5859_5E5F_5C5D},  // R4 len 8 xor
    '{6'h20, 8'h77, 1'b0, 4'd1, 64'h0000_0000_0000_0077},  // R2 len 1
    '{6'h32, 8'h26, 1'b1, 4'd4, 64'h0000_0000_2524_2726}   // R2 write len 4
  };

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_mode(input logic [5:0] w);
    mode_load = 1'b1;
    mode_word = w;
    @(negedge clk);
    mode_load = 1'b0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [1:0] bk, input logic [7:0] col);
    cmd_op   = op;
    cmd_bank = bk;
    cmd_col  = col;
    @(negedge clk);
    cmd_op   = 2'b00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mode_load = 1'b0; mode_word = '0; cmd_op = 2'b00;
    cmd_bank = '0; cmd_col = '0; beat_mask = '0;
    idle(3);
    chk("R1 col_valid in reset", col_valid, 0);
    chk("R1 rd_valid in reset", rd_valid, 0);
    chk("R1 mode_err in reset", mode_err, 0);
    chk("R1 col_mask in reset", col_mask, 0);
    rst = 1'b0;
    idle(2);

    // R1 default mode: length 1, latency 2
    issue(2'b01, 2'd1, 8'h34);
    chk("R2 beat0 valid", col_valid, 1);
    chk("R2 beat0 addr", col_addr, 8'h34);
    chk("R2 beat0 bank", col_bank, 2'd1);
    chk("R2 beat0 read", col_write, 0);
    idle(1);
    chk("R1 default length 1", col_valid, 0);
    chk("R7 rd_valid early", rd_valid, 0);
    idle(1);
    chk("R1 default latency 2", rd_valid, 1);
    idle(1);
    chk("R7 rd_valid single", rd_valid, 0);
    idle(4);

    // table walk: R3 R4 R2
    for (int i = 0; i < 7; i++) begin
      load_mode(TBL[i].mode);
      idle(2);
      issue(TBL[i].wr ? 2'b10 : 2'b01, 2'(i), TBL[i].col);
      for (int k = 0; k < int'(TBL[i].n); k++) begin
        chk($sformatf("R3/R4 vec %0d beat %0d addr", i, k), col_addr, TBL[i].exp[k*8 +: 8]);
        chk($sformatf("R2 vec %0d beat %0d valid", i, k), col_valid, 1);
        if (k == 0) chk($sformatf("R2 vec %0d dir", i), col_write, TBL[i].wr);
        if (k < int'(TBL[i].n) - 1) @(negedge clk);
      end
      @(negedge clk);
      chk($sformatf("R4 vec %0d end of burst", i), col_valid, 0);
      idle(5);
    end

    // R7 latency 3
    load_mode(6'h30);
    idle(2);
    issue(2'b01, 2'd0, 8'h01);
    chk("R7 L3 n+0", rd_valid, 0);
    idle(1); chk("R7 L3 n+1", rd_valid, 0);
    idle(1); chk("R7 L3 n+2", rd_valid, 0);
    idle(1); chk("R7 L3 n+3", rd_valid, 1);
    idle(1); chk("R7 L3 n+4", rd_valid, 0);
    idle(4);

    // R6 rejection
    load_mode(6'h22);
    idle(2);
    load_mode(6'h2F);
    chk("R6 full+xor flagged", mode_err, 1);
    load_mode(6'h24);
    chk("R6 reserved length flagged", mode_err, 1);
    load_mode(6'h12);
    chk("R6 latency 1 flagged", mode_err, 1);
    idle(1);
    issue(2'b01, 2'd0, 8'h26);
    chk("R6 mode kept beat0", col_addr, 8'h26);
    idle(1); chk("R6 mode kept beat1", col_addr, 8'h27);
    idle(1); chk("R6 mode kept beat2", col_addr, 8'h24);
    idle(1); chk("R6 mode kept beat3", col_addr, 8'h25);
    idle(1); chk("R6 mode kept length", col_valid, 0);
    idle(4);
    load_mode(6'h23);
    chk("R6 legal load clears", mode_err, 0);
    idle(2);

    // R5 full page wrap
    load_mode(6'h27);
    idle(2);
    issue(2'b01, 2'd3, 8'hFE);
    begin
      int bad;
      bad = 0;
      for (int k = 0; k < 300; k++) begin
        if (!col_valid || col_addr !== 8'(8'hFE + k)) bad++;
        if (k < 299) @(negedge clk);
      end
      chk("R5 full page walk mismatches", bad, 0);
    end
    cmd_op = 2'b11;
    @(negedge clk);
    cmd_op = 2'b00;
    chk("R8 full page stop", col_valid, 0);
    chk("R8 in-flight read kept", rd_valid, 1);
    idle(5);

    // R8 terminate mid burst
    load_mode(6'h23);
    idle(2);
    issue(2'b01, 2'd0, 8'h10);
    idle(1);
    idle(1);
    chk("R8 beat2 before stop", col_addr, 8'h12);
    cmd_op = 2'b11;
    @(negedge clk);
    cmd_op = 2'b00;
    chk("R8 no beat after terminate", col_valid, 0);
    chk("R8 beat1 data valid", rd_valid, 1);
    idle(1);
    chk("R8 still stopped", col_valid, 0);
    chk("R8 beat2 data valid", rd_valid, 1);
    idle(1);
    chk("R8 no extra data", rd_valid, 0);
    idle(4);

    // R9 interrupt read by write
    issue(2'b01, 2'd0, 8'h10);
    idle(1);
    chk("R9 old beat1", col_addr, 8'h11);
    issue(2'b10, 2'd2, 8'h45);
    chk("R9 new start addr", col_addr, 8'h45);
    chk("R9 new write", col_write, 1);
    chk("R9 new bank", col_bank, 2'd2);
    idle(1);
    chk("R9 new beat1", col_addr, 8'h46);
    chk("R9 old read beat1 data", rd_valid, 1);
    idle(1);
    chk("R9 no data for dropped beats", rd_valid, 0);
    idle(5);
    chk("R9 new beat7", col_addr, 8'h44);
    idle(1);
    chk("R9 new burst ends", col_valid, 0);
    idle(4);

    // R10 mask per beat
    load_mode(6'h22);
    idle(2);
    beat_mask = 2'b01;
    issue(2'b10, 2'd1, 8'h08);
    chk("R10 mask beat0", col_mask, 2'b01);
    beat_mask = 2'b10;
    idle(1); chk("R10 mask beat1", col_mask, 2'b10);
    beat_mask = 2'b11;
    idle(1); chk("R10 mask beat2", col_mask, 2'b11);
    beat_mask = 2'b00;
    idle(1); chk("R10 mask beat3", col_mask, 2'b00);
    beat_mask = 2'b11;
    idle(1);
    chk("R10 mask without beat", col_mask, 2'b00);
    beat_mask = 2'b00;
    idle(4);

    // R11 terminate and idle while nothing runs
    cmd_op = 2'b11;
    @(negedge clk);
    cmd_op = 2'b00;
    chk("R11 idle terminate", col_valid, 0);
    idle(2);
    chk("R11 idle quiet", col_valid, 0);
    chk("R11 idle no data", rd_valid, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule